// File: doc/BRIEF.md
# DDR SDRAM Command Checker

This block sits beside a double-data-rate SDRAM command bus and looks at it once per clock. From the clock-enable pair (the value in the previous cycle and the current one), chip select, the three strobes RAS/CAS/WE, the two bank bits, address bit A10 and the three low mode bits, it names the command on the bus. It reports which bank the command targets and whether an auto-precharge was asked for.

Alongside the decoding it tracks whether each of the four banks has an open row. It also tracks two short timers: a quiet gap after a mode-register write and a blocking window after a write that carries auto-precharge. Any command that breaks a bank-state rule raises a one-cycle flag with an error code. A command that breaks a rule is not applied to the tracked state. Every result is registered, so it appears one clock after the command is sampled.

Top module: `ddr_cmd_monitor`

## Requirements
- R1: Reset is asynchronous and active low. It clears every bank to idle, zeroes the gap and window timers, and sets the burst length back to 2. It drives cmdOut=0 (deselect), bankOut=0, autoPreOut=0, illegal=0 and errCode=0.
- R2: Command codes on cmdOut are: 0 deselect, 1 NOP, 2 mode set, 3 extended mode set, 4 refresh, 5 self-refresh entry, 6 power-down entry, 7 low-power exit, 8 precharge one bank, 9 precharge all, 10 activate, 11 write, 12 read, 13 burst stop. With CS low and clock enable high in both cycles, the (RAS,CAS,WE) levels decode as 000 mode set (extended when BA0=1), 001 refresh, 010 precharge, 011 activate, 100 write, 101 read, 110 burst stop and 111 NOP. CS high decodes as deselect. Each result appears on the outputs one clock after it is sampled.
- R3: For activate, read, write and single-bank precharge, bankOut carries the bank bits as {BA1,BA0}, where 0 to 3 are banks A to D. For every other command bankOut is 0. autoPreOut is 1 only for a read or write with A10 high.
- R4: An activate to an idle bank sets that bank's bit in bankOpen (bit n is bank n). An activate to a bank that is already open gives errCode 3.
- R5: A read or write to an idle bank gives errCode 4.
- R6: Precharge with A10 low closes only the selected bank. With A10 high it closes all banks and the bank bits are ignored.
- R7: Mode set, extended mode set, refresh and self-refresh entry give errCode 1 when any bank is open.
- R8: After an accepted mode set or extended mode set, any command other than NOP or deselect in the next two cycles gives errCode 2.
- R9: A non-extended mode set loads the burst length from the mode bits: 001 gives 2, 010 gives 4 and 011 gives 8. Any other code leaves the burst length unchanged, and an extended mode set never changes it.
- R10: An accepted write with auto-precharge opens a window of burst-length/2 cycles. In that window any read or write to any bank gives errCode 5. The written bank closes on the window's last cycle, and after the window a read or write to another open bank is accepted.
- R11: An accepted read with auto-precharge closes its bank at once.
- R12: Clock enable going from high to low gives self-refresh entry when the strobes encode refresh with CS low, and power-down entry otherwise. Clock enable going from low to high gives low-power exit. Clock enable low in both cycles decodes as NOP. Power-down entry is allowed with banks open.
- R13: Burst stop is accepted at every burst length and in every bank state.
- R14: illegal is 1 exactly when errCode is non-zero, and a flagged command changes no bank state. When more than one rule is broken, the mode gap (2) takes priority over the write window (5), which takes priority over the bank-state errors (1, 3, 4).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ckePrev | input | 1 | Clock enable in the previous cycle |
| ckeCur | input | 1 | Clock enable in this cycle |
| csN | input | 1 | Chip select, active low |
| rasN | input | 1 | Row strobe, active low |
| casN | input | 1 | Column strobe, active low |
| weN | input | 1 | Write enable, active low |
| ba | input | 2 | Bank bits {BA1,BA0} |
| a10 | input | 1 | Address bit 10 (all-bank / auto-precharge) |
| modeBits | input | 3 | Address bits A2..A0 (burst-length code) |
| cmdOut | output | 4 | Decoded command code |
| bankOut | output | 2 | Targeted bank |
| autoPreOut | output | 1 | Auto-precharge requested |
| illegal | output | 1 | One-cycle rule-violation flag |
| errCode | output | 3 | Violated rule, 0 when none |
| bankOpen | output | 4 | Open-row bit for each bank |

## Verification
Every output is due exactly one clock after the command is sampled. This holds for bankOpen too, except at the end of an auto-precharge write window. There the bank bit falls on the edge that samples the window's last command, which is burst-length/2 clocks after the write. The bench drives each command on a falling edge and reads all outputs on the next falling edge. That reading sees the result of the single rising edge in between. The expected timer lengths are counted in those same steps: two for the mode gap, and one, two or four for the window.

// File: rtl/ddr_cmd_pkg.sv
package ddr_cmd_pkg;

  localparam int BANKS = 4;
  localparam int BA_W  = $clog2(BANKS);

  typedef enum logic [3:0] {
    CMD_DESEL   = 4'd0,
    CMD_NOP     = 4'd1,
    CMD_MRS     = 4'd2,
    CMD_EMRS    = 4'd3,
    CMD_REF     = 4'd4,
    CMD_SREF_IN = 4'd5,
    CMD_PDN_IN  = 4'd6,
    CMD_LP_EXIT = 4'd7,
    CMD_PRE     = 4'd8,
    CMD_PREA    = 4'd9,
    CMD_ACT     = 4'd10,
    CMD_WR      = 4'd11,
    CMD_RD      = 4'd12,
    CMD_BST     = 4'd13
  } cmd_e;

  typedef enum logic [2:0] {
    ERR_NONE     = 3'd0,
    ERR_NOT_IDLE = 3'd1,
    ERR_MODE_GAP = 3'd2,
    ERR_ROW_OPEN = 3'd3,
    ERR_ROW_IDLE = 3'd4,
    ERR_WR_BUSY  = 3'd5
  } err_e;

  // Strobes from the rule control to the state datapath
  typedef struct packed {
    logic             accept;
    logic             openEn;
    logic [BANKS-1:0] closeMask;
    err_e             err;
  } strobe_t;

endpackage

// File: rtl/ddr_cmd_decode.sv
module ddr_cmd_decode
  import ddr_cmd_pkg::*;
(
  input  logic            ckePrev,
  input  logic            ckeCur,
  input  logic            csN,
  input  logic            rasN,
  input  logic            casN,
  input  logic            weN,
  input  logic [BA_W-1:0] ba,
  input  logic            a10,
  output cmd_e            cmd,
  output logic [BA_W-1:0] bank,
  output logic            autoPre
);

  logic [2:0] strobes;
  logic       refCode;

  assign strobes = {rasN, casN, weN};
  assign refCode = !csN && (strobes == 3'b001);

  always_comb begin
    cmd = CMD_NOP;
    if (ckePrev && !ckeCur) begin
      cmd = refCode ? CMD_SREF_IN : CMD_PDN_IN;
    end else if (!ckePrev && ckeCur) begin
      cmd = CMD_LP_EXIT;
    end else if (!ckePrev && !ckeCur) begin
      cmd = CMD_NOP;
    end else if (csN) begin
      cmd = CMD_DESEL;
    end else begin
      unique case (strobes)
        3'b000:  cmd = ba[0] ? CMD_EMRS : CMD_MRS;
        3'b001:  cmd = CMD_REF;
        3'b010:  cmd = a10 ? CMD_PREA : CMD_PRE;
        3'b011:  cmd = CMD_ACT;
        3'b100:  cmd = CMD_WR;
        3'b101:  cmd = CMD_RD;
        3'b110:  cmd = CMD_BST;
        default: cmd = CMD_NOP;
      endcase
    end
  end

  always_comb begin
    bank    = '0;
    autoPre = 1'b0;
    if (cmd inside {CMD_ACT, CMD_RD, CMD_WR, CMD_PRE}) bank = ba;
    if (cmd inside {CMD_RD, CMD_WR}) autoPre = a10;
  end

endmodule

// File: rtl/ddr_rule_ctrl.sv
module ddr_rule_ctrl
  import ddr_cmd_pkg::*;
#(
  parameter int MRS_GAP = 2,
  parameter int MAX_BL  = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  cmd_e             cmd,
  input  logic [BA_W-1:0]  bank,
  input  logic             autoPre,
  input  logic [2:0]       modeBits,
  input  logic [BANKS-1:0] bankOpen,
  output strobe_t          strb
);

  localparam int GAP_W = $clog2(MRS_GAP + 1);
  localparam int WIN_W = $clog2(MAX_BL / 2 + 1);

  logic [GAP_W-1:0] gapCnt;
  logic [WIN_W-1:0] winCnt;
  logic [WIN_W-1:0] blHalf;
  logic [BA_W-1:0]  winBank;

  logic isQuiet, isRw, needIdle, isMode, winLast;
  err_e errSel;

  assign isQuiet  = cmd inside {CMD_DESEL, CMD_NOP};
  assign isRw     = cmd inside {CMD_RD, CMD_WR};
  assign needIdle = cmd inside {CMD_MRS, CMD_EMRS, CMD_REF, CMD_SREF_IN};
  assign isMode   = cmd inside {CMD_MRS, CMD_EMRS};
  assign winLast  = (winCnt == WIN_W'(1));

  // Rule priority: mode gap, then write window, then bank state
  always_comb begin
    errSel = ERR_NONE;
    if (!isQuiet && gapCnt != '0)           errSel = ERR_MODE_GAP;
    else if (isRw && winCnt != '0)          errSel = ERR_WR_BUSY;
    else if (needIdle && (|bankOpen))       errSel = ERR_NOT_IDLE;
    else if (cmd == CMD_ACT && bankOpen[bank]) errSel = ERR_ROW_OPEN;
    else if (isRw && !bankOpen[bank])       errSel = ERR_ROW_IDLE;
  end

  always_comb begin
    strb.err       = errSel;
    strb.accept    = (errSel == ERR_NONE);
    strb.openEn    = strb.accept && (cmd == CMD_ACT);
    strb.closeMask = '0;
    if (strb.accept) begin
      if (cmd == CMD_PREA)                  strb.closeMask = '1;
      else if (cmd == CMD_PRE)              strb.closeMask[bank] = 1'b1;
      else if (cmd == CMD_RD && autoPre)    strb.closeMask[bank] = 1'b1;
    end
    if (winLast) strb.closeMask[winBank] = 1'b1;
  end

  // Mode-register gap timer
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gapCnt <= '0;
    end else if (strb.accept && isMode) begin
      gapCnt <= GAP_W'(MRS_GAP);
    end else if (gapCnt != '0) begin
      gapCnt <= gapCnt - GAP_W'(1);
    end
  end

  // Burst length held as half-length in clocks
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      blHalf <= WIN_W'(1);
    end else if (strb.accept && cmd == CMD_MRS) begin
      unique case (modeBits)
        3'b001:  blHalf <= WIN_W'(1);
        3'b010:  blHalf <= WIN_W'(2);
        3'b011:  blHalf <= WIN_W'(4);
        default: blHalf <= blHalf;
      endcase
    end
  end

  // Write-with-auto-precharge blocking window
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      winCnt  <= '0;
      winBank <= '0;
    end else if (strb.accept && cmd == CMD_WR && autoPre) begin
      winCnt  <= blHalf;
      winBank <= bank;
    end else if (winCnt != '0) begin
      winCnt <= winCnt - WIN_W'(1);
    end
  end

  a_r8_gap_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    gapCnt <= GAP_W'(MRS_GAP));

  a_r8_gap_counts_down: assert property (@(posedge clk) disable iff (!rst_n)
    (gapCnt != '0) |=> (gapCnt == $past(gapCnt) - GAP_W'(1)));

  a_r9_bl_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(blHalf) == 1);

  a_r10_window_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    winCnt <= WIN_W'(MAX_BL / 2));

endmodule

// File: rtl/ddr_bank_path.sv
module ddr_bank_path
  import ddr_cmd_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  strobe_t          strb,
  input  cmd_e             cmd,
  input  logic [BA_W-1:0]  bank,
  input  logic             autoPre,
  output cmd_e             cmdQ,
  output logic [BA_W-1:0]  bankQ,
  output logic             autoPreQ,
  output logic             illegalQ,
  output err_e             errQ,
  output logic [BANKS-1:0] openQ
);

  logic [BANKS-1:0] openBit;
  logic [BANKS-1:0] openNext;

  assign openBit  = strb.openEn ? ({{(BANKS-1){1'b0}}, 1'b1} << bank) : '0;
  assign openNext = (openQ & ~strb.closeMask) | openBit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      openQ <= '0;
    end else begin
      openQ <= openNext;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmdQ     <= CMD_DESEL;
      bankQ    <= '0;
      autoPreQ <= 1'b0;
      illegalQ <= 1'b0;
      errQ     <= ERR_NONE;
    end else begin
      cmdQ     <= cmd;
      bankQ    <= bank;
      autoPreQ <= autoPre;
      illegalQ <= !strb.accept;
      errQ     <= strb.err;
    end
  end

  a_r14_flag_matches_code: assert property (@(posedge clk) disable iff (!rst_n)
    illegalQ == (errQ != ERR_NONE));

  a_r14_reject_opens_nothing: assert property (@(posedge clk) disable iff (!rst_n)
    illegalQ |-> ((openQ & ~$past(openQ)) == '0));

  a_r4_act_leaves_open: assert property (@(posedge clk) disable iff (!rst_n)
    (cmdQ == CMD_ACT && !illegalQ) |-> openQ[bankQ]);

  a_r6_prea_all_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (cmdQ == CMD_PREA && !illegalQ) |-> (openQ == '0));

  a_r13_bst_only_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (cmdQ == CMD_BST) |-> (errQ inside {ERR_NONE, ERR_MODE_GAP}));

  a_r3_ap_only_rw: assert property (@(posedge clk) disable iff (!rst_n)
    autoPreQ |-> (cmdQ inside {CMD_RD, CMD_WR}));

endmodule

// File: rtl/ddr_cmd_monitor.sv
module ddr_cmd_monitor
  import ddr_cmd_pkg::*;
#(
  parameter int MRS_GAP = 2,
  parameter int MAX_BL  = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ckePrev,
  input  logic        ckeCur,
  input  logic        csN,
  input  logic        rasN,
  input  logic        casN,
  input  logic        weN,
  input  logic [1:0]  ba,
  input  logic        a10,
  input  logic [2:0]  modeBits,
  output logic [3:0]  cmdOut,
  output logic [1:0]  bankOut,
  output logic        autoPreOut,
  output logic        illegal,
  output logic [2:0]  errCode,
  output logic [3:0]  bankOpen
);

  cmd_e             cmdDec;
  logic [BA_W-1:0]  bankDec;
  logic             apDec;
  strobe_t          strb;
  cmd_e             cmdQ;
  err_e             errQ;
  logic [BANKS-1:0] openQ;

  ddr_cmd_decode u_decode (
    .ckePrev (ckePrev),
    .ckeCur  (ckeCur),
    .csN     (csN),
    .rasN    (rasN),
    .casN    (casN),
    .weN     (weN),
    .ba      (ba),
    .a10     (a10),
    .cmd     (cmdDec),
    .bank    (bankDec),
    .autoPre (apDec)
  );

  ddr_rule_ctrl #(
    .MRS_GAP (MRS_GAP),
    .MAX_BL  (MAX_BL)
  ) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmd      (cmdDec),
    .bank     (bankDec),
    .autoPre  (apDec),
    .modeBits (modeBits),
    .bankOpen (openQ),
    .strb     (strb)
  );

  ddr_bank_path u_path (
    .clk      (clk),
    .rst_n    (rst_n),
    .strb     (strb),
    .cmd      (cmdDec),
    .bank     (bankDec),
    .autoPre  (apDec),
    .cmdQ     (cmdQ),
    .bankQ    (bankOut),
    .autoPreQ (autoPreOut),
    .illegalQ (illegal),
    .errQ     (errQ),
    .openQ    (openQ)
  );

  assign cmdOut   = cmdQ;
  assign errCode  = errQ;
  assign bankOpen = openQ;

endmodule

// File: tb/ddr_cmd_monitor_bench.sv
module ddr_cmd_monitor_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ckePrev = 1'b1, ckeCur = 1'b1;
  logic       csN = 1'b0, rasN = 1'b1, casN = 1'b1, weN = 1'b1;
  logic [1:0] ba = 2'd0;
  logic       a10 = 1'b0;
  logic [2:0] modeBits = 3'd0;
  logic [3:0] cmdOut;
  logic [1:0] bankOut;
  logic       autoPreOut, illegal;
  logic [2:0] errCode;
  logic [3:0] bankOpen;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  ddr_cmd_monitor u_ddr_cmd_monitor (
    .clk (clk), .rst_n (rst_n), .ckePrev (ckePrev), .ckeCur (ckeCur),
    .csN (csN), .rasN (rasN), .casN (casN), .weN (weN), .ba (ba),
    .a10 (a10), .modeBits (modeBits), .cmdOut (cmdOut), .bankOut (bankOut),
    .autoPreOut (autoPreOut), .illegal (illegal), .errCode (errCode),
    .bankOpen (bankOpen)
  );

  // Row: req[30:27] | stim P,C,cs,ras,cas,we,ba[2],a10,mode[3] | exp cmd[4],bank[2],ap,ill,err[3],open[4]
  localparam int NV = 61;
  localparam logic [30:0] VEC [NV] = '{
    31'b0010_1_1_0_111_00_0_000_0001_00_0_0_000_0000, // 0  R2 NOP
    31'b0010_1_1_1_111_00_0_000_0000_00_0_0_000_0000, // 1  R2 deselect
    31'b1001_1_1_0_000_00_0_010_0010_00_0_0_000_0000, // 2  R9 mode set BL4
    31'b1000_1_1_0_011_01_0_000_1010_01_0_1_010_0000, // 3  R8 ACT in gap
    31'b1000_1_1_0_111_00_0_000_0001_00_0_0_000_0000, // 4  R8 NOP in gap
    31'b0100_1_1_0_011_01_0_000_1010_01_0_0_000_0010, // 5  R4 ACT b1
    31'b0100_1_1_0_011_01_0_000_1010_01_0_1_011_0010, // 6  R4 ACT open b1
    31'b0101_1_1_0_101_00_0_000_1100_00_0_1_100_0010, // 7  R5 RD idle b0
    31'b0011_1_1_0_101_01_0_000_1100_01_0_0_000_0010, // 8  R3 RD b1
    31'b0111_1_1_0_001_00_0_000_0100_00_0_1_001_0010, // 9  R7 REF open
    31'b0100_1_1_0_011_10_0_000_1010_10_0_0_000_0110, // 10 R4 ACT b2
    31'b0011_1_1_0_100_01_1_000_1011_01_1_0_000_0110, // 11 R3 WR-AP b1
    31'b1110_1_1_0_101_00_0_000_1100_00_0_1_101_0110, // 12 R14 busy beats idle
    31'b1010_1_1_0_100_10_0_000_1011_10_0_1_101_0100, // 13 R10 WR busy, b1 closes
    31'b1010_1_1_0_101_10_0_000_1100_10_0_0_000_0100, // 14 R10 RD b2 after window
    31'b0101_1_1_0_100_01_0_000_1011_01_0_1_100_0100, // 15 R5 WR idle b1
    31'b1101_1_1_0_110_00_0_000_1101_00_0_0_000_0100, // 16 R13 BST
    31'b1011_1_1_0_101_10_1_000_1100_10_1_0_000_0000, // 17 R11 RD-AP b2
    31'b0100_1_1_0_011_11_0_000_1010_11_0_0_000_1000, // 18 R4 ACT b3
    31'b0100_1_1_0_011_00_0_000_1010_00_0_0_000_1001, // 19 R4 ACT b0
    31'b0110_1_1_0_010_11_0_000_1000_11_0_0_000_0001, // 20 R6 PRE b3
    31'b0110_1_1_0_010_10_1_000_1001_00_0_0_000_0000, // 21 R6 PREA ba ignored
    31'b1000_1_1_0_000_01_0_011_0011_00_0_0_000_0000, // 22 R8 ext mode set
    31'b1000_1_1_0_001_00_0_000_0100_00_0_1_010_0000, // 23 R8 REF in gap
    31'b1000_1_1_1_111_00_0_000_0000_00_0_0_000_0000, // 24 R8 deselect in gap
    31'b0111_1_1_0_001_00_0_000_0100_00_0_0_000_0000, // 25 R7 REF idle
    31'b1100_1_0_0_001_00_0_000_0101_00_0_0_000_0000, // 26 R12 self-refresh in
    31'b1100_0_0_1_111_00_0_000_0001_00_0_0_000_0000, // 27 R12 held low
    31'b1100_0_1_1_111_00_0_000_0111_00_0_0_000_0000, // 28 R12 exit
    31'b0100_1_1_0_011_00_0_000_1010_00_0_0_000_0001, // 29 R4 ACT b0
    31'b1100_1_0_1_111_00_0_000_0110_00_0_0_000_0001, // 30 R12 power-down open
    31'b1100_0_1_1_111_00_0_000_0111_00_0_0_000_0001, // 31 R12 exit
    31'b0111_1_0_0_001_00_0_000_0101_00_0_1_001_0001, // 32 R7 self-refresh open
    31'b1010_1_1_0_100_00_1_000_1011_00_1_0_000_0001, // 33 R10 WR-AP b0, BL4
    31'b1010_1_1_0_111_00_0_000_0001_00_0_0_000_0001, // 34 R10
    31'b1010_1_1_0_111_00_0_000_0001_00_0_0_000_0000, // 35 R10 b0 closed
    31'b1010_1_1_0_101_00_0_000_1100_00_0_1_100_0000, // 36 R10 RD closed b0
    31'b1001_1_1_0_000_00_0_011_0010_00_0_0_000_0000, // 37 R9 BL8
    31'b1000_1_1_0_111_00_0_000_0001_00_0_0_000_0000, // 38
    31'b1000_1_1_0_111_00_0_000_0001_00_0_0_000_0000, // 39
    31'b0100_1_1_0_011_10_0_000_1010_10_0_0_000_0100, // 40 R4 ACT b2
    31'b1001_1_1_0_100_10_1_000_1011_10_1_0_000_0100, // 41 R9 WR-AP b2
    31'b1001_1_1_0_101_10_0_000_1100_10_0_1_101_0100, // 42 R9
    31'b1001_1_1_0_111_00_0_000_0001_00_0_0_000_0100, // 43 R9
    31'b1001_1_1_0_111_00_0_000_0001_00_0_0_000_0100, // 44 R9
    31'b1001_1_1_0_111_00_0_000_0001_00_0_0_000_0000, // 45 R9 closed after 4
    31'b1001_1_1_0_000_00_0_111_0010_00_0_0_000_0000, // 46 R9 bad code keeps BL8
    31'b1000_1_1_0_111_00_0_000_0001_00_0_0_000_0000, // 47
    31'b1000_1_1_0_111_00_0_000_0001_00_0_0_000_0000, // 48
    31'b0100_1_1_0_011_00_0_000_1010_00_0_0_000_0001, // 49 R4 ACT b0
    31'b1001_1_1_0_100_00_1_000_1011_00_1_0_000_0001, // 50 R9 WR-AP b0
    31'b1001_1_1_0_111_00_0_000_0001_00_0_0_000_0001, // 51 R9
    31'b1001_1_1_0_111_00_0_000_0001_00_0_0_000_0001, // 52 R9
    31'b1001_1_1_0_111_00_0_000_0001_00_0_0_000_0001, // 53 R9
    31'b1001_1_1_0_111_00_0_000_0001_00_0_0_000_0000, // 54 R9 closed after 4
    31'b1001_1_1_0_000_00_0_001_0010_00_0_0_000_0000, // 55 R9 BL2
    31'b1000_1_1_0_111_00_0_000_0001_00_0_0_000_0000, // 56
    31'b1000_1_1_0_111_00_0_000_0001_00_0_0_000_0000, // 57
    31'b0100_1_1_0_011_01_0_000_1010_01_0_0_000_0010, // 58 R4 ACT b1
    31'b1001_1_1_0_100_01_1_000_1011_01_1_0_000_0010, // 59 R9 WR-AP b1
    31'b1001_1_1_0_111_00_0_000_0001_00_0_0_000_0000  // 60 R9 closed after 1
  };

  function automatic string reqName(input logic [3:0] r);
    case (r)
      4'd1:  return "R1";
      4'd2:  return "R2";
      4'd3:  return "R3";
      4'd4:  return "R4";
      4'd5:  return "R5";
      4'd6:  return "R6";
      4'd7:  return "R7";
      4'd8:  return "R8";
      4'd9:  return "R9";
      4'd10: return "R10";
      4'd11: return "R11";
      4'd12: return "R12";
      4'd13: return "R13";
      default: return "R14";
    endcase
  endfunction

  function automatic logic [14:0] outs();
    return {cmdOut, bankOut, autoPreOut, illegal, errCode, bankOpen};
  endfunction

  task automatic check(input string req, input string what, input logic [14:0] exp);
    logic [14:0] act;
    act = outs();
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  task automatic drive(input logic [11:0] s);
    {ckePrev, ckeCur, csN, rasN, casN, weN, ba, a10, modeBits} = s;
  endtask

  // Apply at a falling edge, result read at the next falling edge
  task automatic step(input logic [11:0] s);
    drive(s);
    @(negedge clk);
  endtask

  localparam logic [11:0] S_NOP = 12'b1_1_0_111_00_0_000;

  initial begin
    #2000000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    drive(S_NOP);
    repeat (3) @(negedge clk);
    check("R1", "reset state", 15'b0000_00_0_0_000_0000);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      step(VEC[i][26:15]);
      check(reqName(VEC[i][30:27]), $sformatf("row %0d", i), VEC[i][14:0]);
    end

    // R1: reset in the middle of activity clears an open bank
    step(12'b1_1_0_011_11_0_000);
    check("R4", "ACT b3 before reset", 15'b1010_11_0_0_000_1000);
    drive(S_NOP);
    rst_n = 1'b0;
    #1;
    check("R1", "async reset clears", 15'b0000_00_0_0_000_0000);
    @(negedge clk);
    rst_n = 1'b1;

    // R1: reset drops the mode gap and restores burst length 2
    step(12'b1_1_0_000_00_0_011);
    check("R9", "mode set BL8", 15'b0010_00_0_0_000_0000);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    step(12'b1_1_0_011_00_0_000);
    check("R1", "no gap after reset", 15'b1010_00_0_0_000_0001);
    step(12'b1_1_0_100_00_1_000);
    check("R1", "WR-AP after reset", 15'b1011_00_1_0_000_0001);
    step(S_NOP);
    check("R1", "BL2 window after reset", 15'b0001_00_0_0_000_0000);

    // R14: gap outranks a bank-state fault
    step(12'b1_1_0_011_10_0_000);
    check("R4", "ACT b2", 15'b1010_10_0_0_000_0100);
    step(12'b1_1_0_000_00_0_010);
    check("R7", "mode set with open bank", 15'b0010_00_0_1_001_0100);
    step(12'b1_1_0_010_10_0_000);
    check("R6", "PRE b2", 15'b1000_10_0_0_000_0000);
    step(12'b1_1_0_000_00_0_010);
    check("R9", "mode set BL4", 15'b0010_00_0_0_000_0000);
    step(12'b1_1_0_101_01_0_000);
    check("R14", "gap beats idle read", 15'b1100_01_0_1_010_0000);
    step(12'b1_1_0_110_00_0_000);
    check("R13", "BST in gap", 15'b1101_00_0_1_010_0000);
    step(12'b1_1_0_110_00_0_000);
    check("R13", "BST after gap", 15'b1101_00_0_0_000_0000);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule